// File: doc/BRIEF.md
# Dual-Precision Magnitude Comparator

This block compares the magnitude fields of two 64-bit floating-point operand words and reports three flags: A's magnitude is below B's, the two magnitudes match, and both magnitudes are zero. A single select pin picks the format. With the pin high, only bits [30:0] form the magnitude (single precision). With the pin low, bits [62:31] join them (double precision). The sign bit never takes part.

The magnitude is split into a 31-bit low segment and a 32-bit high segment, and each segment has its own comparator. Double precision extends the low result through the high segment: A is below B when its high segment is smaller, or when the high segments match and its low segment is smaller. Each output flag then passes through a 1-bit 2:1 selector. The operands never pass through a wide multiplexer.

The surrounding compare unit applies sign, NaN and exception rules on top of these flags. The block is purely combinational and has no clock or reset.

Top module: `mag_cmp_dual`

## Requirements
- R1: With `sel_single`=1, `mag_eq` is 1 exactly when bits [30:0] of both operands are identical.
- R2: With `sel_single`=0, `mag_eq` is 1 exactly when bits [62:0] of both operands are identical.
- R3: With `sel_single`=1, `mag_lt` is 1 exactly when the unsigned value of `op_a`[30:0] is below that of `op_b`[30:0].
- R4: With `sel_single`=0, `mag_lt` is 1 exactly when the unsigned value of `op_a`[62:0] is below that of `op_b`[62:0].
- R5: With `sel_single`=1, `mag_both_zero` is 1 exactly when bits [30:0] of both operands are all zero.
- R6: With `sel_single`=0, `mag_both_zero` is 1 exactly when bits [62:0] of both operands are all zero.
- R7: With `sel_single`=1, the values in bits [63:31] of either operand have no effect on any output.
- R8: In both modes, bit 63 of either operand has no effect on any output.
- R9: `mag_lt` and `mag_eq` are never both 1, and `mag_both_zero`=1 implies `mag_eq`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 64 | Operand word A |
| op_b | input | 64 | Operand word B |
| sel_single | input | 1 | 1 = single-precision magnitude [30:0], 0 = double [62:0] |
| mag_lt | output | 1 | Magnitude of A below magnitude of B |
| mag_eq | output | 1 | Magnitudes identical |
| mag_both_zero | output | 1 | Both magnitudes zero |

## Verification
Equality and the both-zero flag can be true at the same time, and so can a less-than result and a high segment that holds arbitrary data. The bench produces the first case with zero operands whose upper bits contain garbage, in each mode. It produces the second case with operands that differ only at bit 30 or bit 31, and with random upper halves under single precision. Every flag is compared against 63-bit comparisons on zero-padded values computed in the bench. A flipped high half must change nothing in single mode, and a flipped sign bit must change nothing in either mode.

// File: rtl/mag_cmp_pkg.sv
package mag_cmp_pkg;
  localparam int unsigned WORD_W = 64;
  localparam int unsigned LO_W   = 31;
  localparam int unsigned HI_W   = 32;
  localparam int unsigned MAG_W  = LO_W + HI_W;

  typedef struct packed {
    logic lt;
    logic eq;
    logic zero;
  } seg_flags_t;
endpackage

// File: rtl/mag_seg_cmp.sv
module mag_seg_cmp #(
  parameter int unsigned W = 31
) (
  input  logic [W-1:0] seg_a,
  input  logic [W-1:0] seg_b,
  output mag_cmp_pkg::seg_flags_t flags
);
  logic [W-1:0] same_bit;
  logic [W-1:0] any_set;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign same_bit[i] = ~(seg_a[i] ^ seg_b[i]);
    assign any_set[i]  = seg_a[i] | seg_b[i];
  end

  assign flags.eq   = &same_bit;
  assign flags.zero = ~(|any_set);
  assign flags.lt   = seg_a < seg_b;

  always_comb begin
    assert_seg_lt_eq_excl_R9: assert (!(flags.lt && flags.eq))
      else $error("segment lt and eq both set");
    assert_seg_zero_eq_R9: assert (!flags.zero || flags.eq)
      else $error("segment zero without eq");
  end
endmodule

// File: rtl/mag_prec_sel.sv
module mag_prec_sel (
  input  logic                    single_mode,
  input  mag_cmp_pkg::seg_flags_t lo,
  input  mag_cmp_pkg::seg_flags_t hi,
  output mag_cmp_pkg::seg_flags_t res
);
  mag_cmp_pkg::seg_flags_t dbl;

  always_comb begin
    dbl.eq   = hi.eq & lo.eq;
    dbl.zero = hi.zero & lo.zero;
    dbl.lt   = hi.lt | (hi.eq & lo.lt);
  end

  assign res.eq   = single_mode ? lo.eq   : dbl.eq;
  assign res.zero = single_mode ? lo.zero : dbl.zero;
  assign res.lt   = single_mode ? lo.lt   : dbl.lt;

  always_comb begin
    if (!single_mode) begin
      assert_hi_lt_wins_R4: assert (!hi.lt || res.lt)
        else $error("upper segment less-than not propagated");
      assert_hi_diff_blocks_eq_R2: assert (hi.eq || !res.eq)
        else $error("equal reported with differing upper segment");
    end else begin
      assert_single_follows_lo_R7: assert (res.lt == lo.lt && res.eq == lo.eq)
        else $error("single mode result not from low segment");
    end
  end
endmodule

// File: rtl/mag_cmp_dual.sv
module mag_cmp_dual #(
  parameter int unsigned WORD_W = mag_cmp_pkg::WORD_W,
  parameter int unsigned LO_W   = mag_cmp_pkg::LO_W,
  parameter int unsigned HI_W   = mag_cmp_pkg::HI_W
) (
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  input  logic              sel_single,
  output logic              mag_lt,
  output logic              mag_eq,
  output logic              mag_both_zero
);
  localparam int unsigned HI_LSB = LO_W;
  localparam int unsigned HI_MSB = LO_W + HI_W - 1;

  mag_cmp_pkg::seg_flags_t lo_f, hi_f, res_f;

  mag_seg_cmp #(.W(LO_W)) u_lo (
    .seg_a (op_a[LO_W-1:0]),
    .seg_b (op_b[LO_W-1:0]),
    .flags (lo_f)
  );

  mag_seg_cmp #(.W(HI_W)) u_hi (
    .seg_a (op_a[HI_MSB:HI_LSB]),
    .seg_b (op_b[HI_MSB:HI_LSB]),
    .flags (hi_f)
  );

  mag_prec_sel u_sel (
    .single_mode (sel_single),
    .lo          (lo_f),
    .hi          (hi_f),
    .res         (res_f)
  );

  assign mag_lt        = res_f.lt;
  assign mag_eq        = res_f.eq;
  assign mag_both_zero = res_f.zero;

  always_comb begin
    assert_lt_eq_excl_R9: assert (!(mag_lt && mag_eq))
      else $error("lt and eq both set");
    assert_zero_implies_eq_R9: assert (!mag_both_zero || mag_eq)
      else $error("zero without eq");
  end
endmodule

// File: tb/mag_cmp_dual_bench.sv
module mag_cmp_dual_bench;
  logic        clk = 1'b0;
  logic [63:0] op_a = '0, op_b = '0;
  logic        sel_single = 1'b1;
  logic        mag_lt, mag_eq, mag_both_zero;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  mag_cmp_dual u_mag_cmp_dual (
    .op_a(op_a), .op_b(op_b), .sel_single(sel_single),
    .mag_lt(mag_lt), .mag_eq(mag_eq), .mag_both_zero(mag_both_zero)
  );

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h s=%0b act=%0b exp=%0b", req, op_a, op_b, sel_single, act, exp);
    end
  endtask

  task automatic apply(logic [63:0] a, logic [63:0] b, logic s);
    logic [62:0] ma, mb;
    @(posedge clk);
    op_a = a; op_b = b; sel_single = s;
    @(negedge clk);
    ma = s ? {32'd0, a[30:0]} : a[62:0];
    mb = s ? {32'd0, b[30:0]} : b[62:0];
    if (s) begin
      chk("R1", mag_eq, ma == mb);
      chk("R3", mag_lt, ma < mb);
      chk("R5", mag_both_zero, (ma | mb) == 63'd0);
    end else begin
      chk("R2", mag_eq, ma == mb);
      chk("R4", mag_lt, ma < mb);
      chk("R6", mag_both_zero, (ma | mb) == 63'd0);
    end
    chk("R9", mag_lt & mag_eq, 1'b0);
  endtask

  task automatic invariance(logic [63:0] a, logic [63:0] b, logic s,
                            logic [63:0] fa, logic [63:0] fb, string req);
    logic l0, e0, z0;
    apply(a, b, s);
    l0 = mag_lt; e0 = mag_eq; z0 = mag_both_zero;
    @(posedge clk);
    op_a = a ^ fa; op_b = b ^ fb;
    @(negedge clk);
    chk(req, mag_lt, l0);
    chk(req, mag_eq, e0);
    chk(req, mag_both_zero, z0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    chk("R5", mag_both_zero, 1'b1);
    chk("R1", mag_eq, 1'b1);
    for (int s = 0; s < 2; s++) begin
      apply('0, '0, s[0]);
      apply(64'hFFFF_FFFF_8000_0000, 64'h7FFF_0000_8000_0000, s[0]);
      apply(64'h0000_0000_4000_0000, 64'h0, s[0]);
      apply(64'h0, 64'h0000_0000_4000_0000, s[0]);
      apply(64'h0000_0000_8000_0000, 64'h0, s[0]);
      apply(64'h0, 64'h0000_0000_8000_0000, s[0]);
      apply(64'h0000_0001_0000_0000, 64'h0000_0000_7FFF_FFFF, s[0]);
      apply(64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, s[0]);
      apply(64'h8000_0000_0000_0000, 64'h0, s[0]);
      for (int i = 0; i < 31; i++) begin
        apply(64'd1 << i, 64'd1 << i, s[0]);
        apply(64'd1 << i, 64'd0, s[0]);
        apply(64'd0, 64'd1 << (i + 31), s[0]);
      end
    end
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = (i % 4 == 0) ? a ^ ({$urandom, $urandom} & 64'hFFFF_FFFF_8000_0000) : {$urandom, $urandom};
      if (i % 7 == 0) b[62:31] = a[62:31];
      apply(a, b, i[0]);
    end
    for (int i = 0; i < 200; i++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = (i % 3 == 0) ? a : {$urandom, $urandom};
      if (i % 5 == 0) begin a[30:0] = '0; b[30:0] = '0; end
      invariance(a, b, 1'b1, {$urandom, $urandom} & 64'hFFFF_FFFF_8000_0000,
                 {$urandom, $urandom} & 64'hFFFF_FFFF_8000_0000, "R7");
      invariance(a, b, i[0], 64'h8000_0000_0000_0000, {i[1], 63'd0}, "R8");
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule